// File: doc/BRIEF.md
# Timer Input Edge Detector with Noise Filter

This block turns one asynchronous timer input pin into a single-cycle event that marks a valid edge. A timer uses that event in one of two ways. It can count it as its clock, or it can use it as a capture or clear trigger. The valid edge is programmable: rising, falling, both, or none.

Before an edge counts, a two-flop synchronizer and a two-sample level filter condition the pin. The filter takes a new level only after two successive sampling ticks have seen it. In count use, a tick happens on every system clock. In capture use, the ticks come from a strobe driven by an external prescaler.

While the timer is stopped, the pin is ignored. The filtered level starts low out of reset. As a result, a pin that is already high produces one rising event when the timer is first enabled. After that first enable, the filter keeps following the pin quietly while the timer is stopped. A later restart with the pin high therefore produces no event.

Top module: `tmr_edge_filter`

## Requirements
- R1: With `edge_sel` = 2'b01, only low-to-high transitions of the filtered level produce an event.
- R2: With `edge_sel` = 2'b10, only high-to-low transitions of the filtered level produce an event.
- R3: With `edge_sel` = 2'b11, transitions in both directions produce an event.
- R4: With `edge_sel` = 2'b00, no event is ever produced.
- R5: A new pin level is accepted only after two consecutive sampling ticks have seen it. A level that lasts for fewer ticks is discarded as noise.
- R6: With `use_capture` = 0, every system clock is a sampling tick.
- R7: With `use_capture` = 1, sampling happens only in cycles where `presc_tick` is high. No event is issued in a cycle where `presc_tick` is low.
- R8: While `run_en` is low, `edge_evt` stays low and pin activity causes no event.
- R9: After reset, the filtered level is low. If the pin is high on the first enable and rising or both edges are selected, one rising event follows.
- R10: When the timer is re-enabled after a stop with the pin high, and the pin was already high during the stop, no event is produced.
- R11: `edge_evt` is high for exactly one system clock per accepted edge.
- R12: In count use, an accepted edge shows on `edge_evt` after the fourth rising clock edge that follows the pin change: two synchronizer stages, two filter samples, and the output register.
- R13: During reset and directly after it, `edge_evt` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Timer running; when low the pin is ignored |
| pin_raw | input | 1 | Asynchronous timer input pin |
| edge_sel | input | 2 | Valid edge: 01 rising, 10 falling, 11 both, 00 none |
| use_capture | input | 1 | 0 = count use (sample every clock), 1 = capture use (sample on tick) |
| presc_tick | input | 1 | Sampling strobe from the prescaler, used in capture use |
| edge_evt | output | 1 | One-clock valid-edge event |

## Verification
The bench drives a one-cycle glitch and a two-cycle pulse. A filter with only one sample of depth would pass the glitch through, and a filter that is too strict would drop the pulse. It holds the pin high across reset and then enables the timer. A design that seeds the level from the pin would miss the expected spurious rise. It also stops the timer, raises the pin, and restarts. A design that freezes the level during a stop would then fire a false rise. In capture use, ticks are sparse and random. A design that samples on every clock would accept levels early, and the per-cycle comparison with the bench model shows this.

// File: rtl/tmr_edge_filter.sv
module tmr_edge_filter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic       pin_raw,
  input  logic [1:0] edge_sel,
  input  logic       use_capture,
  input  logic       presc_tick,
  output logic       edge_evt
);
  logic sync_a, sync_b, cand, lvl, armed;
  logic tick, settled, rise, fall, hit;

  assign tick    = use_capture ? presc_tick : 1'b1;
  assign settled = (sync_b == cand);
  assign rise    = settled &  sync_b & ~lvl;
  assign fall    = settled & ~sync_b &  lvl;
  assign hit     = (rise & edge_sel[0]) | (fall & edge_sel[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a   <= 1'b0;
      sync_b   <= 1'b0;
      cand     <= 1'b0;
      lvl      <= 1'b0;
      armed    <= 1'b0;
      edge_evt <= 1'b0;
    end else begin
      sync_a <= pin_raw;
      sync_b <= sync_a;
      if (run_en) begin
        armed    <= 1'b1;
        edge_evt <= tick & hit;
        if (tick) begin
          cand <= sync_b;
          if (settled) lvl <= sync_b;
        end
      end else begin
        edge_evt <= 1'b0;
        if (armed) begin
          cand <= sync_b;
          lvl  <= sync_b;
        end
      end
    end
  end
endmodule

module tmr_edge_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run_en,
  input logic [1:0] edge_sel,
  input logic       use_capture,
  input logic       presc_tick,
  input logic       edge_evt
);
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) edge_evt |=> !edge_evt); // R11
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !run_en |=> !edge_evt); // R8
  AST_NONE_SEL: assert property (@(posedge clk) disable iff (!rst_n) (edge_sel == 2'b00) |=> !edge_evt); // R4
  AST_CAP_TICK: assert property (@(posedge clk) disable iff (!rst_n) (use_capture && !presc_tick) |=> !edge_evt); // R7
  AST_RESET_LOW: assert property (@(posedge clk) !rst_n |=> !edge_evt); // R13
endmodule

bind tmr_edge_filter tmr_edge_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .edge_sel(edge_sel),
  .use_capture(use_capture), .presc_tick(presc_tick), .edge_evt(edge_evt)
);

// File: tb/tmr_edge_filter_bench.sv
module tmr_edge_filter_bench;
  logic clk = 1'b0;
  logic rst_n, run_en, pin_raw, use_capture, presc_tick;
  logic [1:0] edge_sel;
  logic edge_evt;
  int total = 0, bad = 0, evt_cnt;
  bit done = 0;
  logic m_a, m_b, m_c, m_l, m_arm, m_e;

  always #2 clk = ~clk;

  tmr_edge_filter u_tmr_edge_filter (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .pin_raw(pin_raw),
    .edge_sel(edge_sel), .use_capture(use_capture), .presc_tick(presc_tick),
    .edge_evt(edge_evt)
  );

  function automatic string sel_tag(logic r, logic [1:0] s, logic cap);
    if (!r) return "R8";
    if (s == 2'b00) return "R4";
    if (cap) return "R7";
    return (s == 2'b01) ? "R1" : (s == 2'b10) ? "R2" : "R3";
  endfunction

  task automatic check(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: edge_evt=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected behaviour model, advanced once per clock
  task automatic model_step();
    logic tk, same, want;
    if (!rst_n) begin
      {m_a, m_b, m_c, m_l, m_arm, m_e} = '0;
      return;
    end
    tk   = use_capture ? presc_tick : 1'b1;
    same = (m_b == m_c);
    want = same && (m_b != m_l) && (m_b ? edge_sel[0] : edge_sel[1]);
    if (run_en) begin
      m_e = tk && want;
      if (tk) begin
        if (same) m_l = m_b;
        m_c = m_b;
      end
      m_arm = 1'b1;
    end else begin
      m_e = 1'b0;
      if (m_arm) begin m_c = m_b; m_l = m_b; end
    end
    m_b = m_a;
    m_a = pin_raw;
  endtask

  task automatic cyc(string tag = "");
    model_step();
    @(posedge clk);
    @(negedge clk);
    if (edge_evt) evt_cnt++;
    check(tag == "" ? sel_tag(run_en, edge_sel, use_capture) : tag, edge_evt, m_e);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 0; run_en = 0; pin_raw = 1; edge_sel = 2'b01;
    use_capture = 0; presc_tick = 0;
    repeat (3) cyc("R13");
    rst_n = 1;
    cyc("R13");
    repeat (5) cyc("R8");
    // first enable with pin high: one spurious rise (R9)
    run_en = 1; evt_cnt = 0;
    repeat (4) cyc("R9");
    total++; if (evt_cnt != 1) begin bad++; $display("FAIL R9: events=%0d expected=1", evt_cnt); end
    // stop, drop pin, raise pin while stopped, restart: no event (R10)
    pin_raw = 0; repeat (6) cyc("R1");
    run_en = 0; repeat (2) cyc("R8");
    pin_raw = 1; evt_cnt = 0; repeat (6) cyc("R8");
    run_en = 1; repeat (8) cyc("R10");
    total++; if (evt_cnt != 0) begin bad++; $display("FAIL R10: events=%0d expected=0", evt_cnt); end
    // glitch rejection and two-cycle acceptance, both edges (R5)
    edge_sel = 2'b11; pin_raw = 0; repeat (6) cyc("R3");
    evt_cnt = 0; pin_raw = 1; cyc("R5"); pin_raw = 0; repeat (8) cyc("R5");
    total++; if (evt_cnt != 0) begin bad++; $display("FAIL R5: glitch events=%0d expected=0", evt_cnt); end
    evt_cnt = 0; pin_raw = 1; repeat (2) cyc("R5"); pin_raw = 0; repeat (8) cyc("R5");
    total++; if (evt_cnt != 2) begin bad++; $display("FAIL R5: pulse events=%0d expected=2", evt_cnt); end
    // latency and width in count use (R12, R11, R6)
    pin_raw = 1;
    repeat (3) begin cyc("R12"); total++; if (edge_evt !== 1'b0) begin bad++; $display("FAIL R12: early edge_evt=%0b expected=0", edge_evt); end end
    cyc("R6"); total++; if (edge_evt !== 1'b1) begin bad++; $display("FAIL R12: edge_evt=%0b expected=1", edge_evt); end
    cyc("R11"); total++; if (edge_evt !== 1'b0) begin bad++; $display("FAIL R11: edge_evt=%0b expected=0", edge_evt); end
    // random mix of selections, uses, ticks and enables
    for (int blk = 0; blk < 120; blk++) begin
      edge_sel = 2'($urandom % 4);
      use_capture = 1'($urandom % 2);
      run_en = ($urandom % 6) != 0;
      for (int k = 0; k < 80; k++) begin
        if ($urandom % 4 == 0) pin_raw = ~pin_raw;
        presc_tick = ($urandom % 3) == 0;
        cyc();
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule